// File: doc/BRIEF.md
# Coherent-Snapshot 64-bit Tick Counter

This block keeps a 64-bit count that advances by one on every clock cycle in which the reference tick input is high. Software cannot read 64 bits in one access, so the count is taken through a snapshot. Software writes a control word with the latch-request bit set. The block raises a busy flag, waits a fixed number of cycles, and then copies the running count into a snapshot register. When the copy is done it clears the busy flag by itself.

Software polls the control word until busy reads 0. It then reads the two 32-bit halves of the snapshot in either order. Both halves come from the same copy, so the pair always forms one count, even while the counter keeps running. Access is a simple word bus: a write strobe with address and data, and a read path in which the data follows the address combinationally.

Top module: `snapcnt_top`

## Requirements
- R1: After reset the count is zero, the busy flag reads 0 and both snapshot halves read zero.
- R2: The count rises by exactly one in each cycle in which `tick` is high, and holds in each cycle in which `tick` is low.
- R3: Once the count reaches all ones, the next tick takes it to zero.
- R4: The latch-request bit is bit 1 of the control word at address 0xA0. A write to 0xA0 with bit 1 set, made while idle, makes bit 1 read 1 from the next cycle. Bit 1 stays 1 for exactly LATCH_DLY cycles and then returns to 0 without further action.
- R5: When busy returns to 0, the snapshot holds the count that was present in the last cycle in which busy read 1.
- R6: Address 0xA4 returns snapshot bits 31:0 and address 0xA8 returns snapshot bits 63:32. Both halves come from the same captured value.
- R7: Between latch requests the snapshot keeps its value while the count keeps advancing.
- R8: A latch request written while busy is already 1 is absorbed. It neither restarts nor extends the wait.
- R9: A control write with bit 1 clear has no effect. Writes to 0xA4 and 0xA8 also have no effect: they neither start a latch nor change the snapshot.
- R10: A read of the control word returns the busy flag in bit 1 and zeros in every other bit. Any address other than 0xA0, 0xA4 and 0xA8 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick enable; the count advances when high |
| wr_en | input | 1 | Write strobe for the register word at `addr` |
| addr | input | ADDR_W | Register address for both writes and reads |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |

## Verification
A wrong count or a capture taken on the wrong edge shows up at the first snapshot after the fault. The value read back then differs from a tick-accurate model by one or more ticks. A busy flag that drops early, lingers, or restarts on a second request changes the number of polled busy cycles, and that difference appears within LATCH_DLY cycles of the request. A snapshot that moves on its own, or halves taken from different captures, show up on a re-read with no request in between. They also show up in a mismatch between the high and low words. Wrap-around is exercised through a narrow second instance, which passes its all-ones count within a few hundred cycles.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
   // Register word addresses; the halves must sit one word apart, low first.
   localparam logic [7:0] ADR_CTRL   = 8'hA0;
   localparam logic [7:0] ADR_HALF0  = 8'hA4;
   localparam int         HALF_STEP  = 4;
   localparam int         REQ_BIT    = 1;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_HALF
   } reg_sel_e;
endpackage

// File: rtl/snapcnt_counter.sv
module snapcnt_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 2) begin : g_bad_width
      $error("snapcnt_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (tick) count <= count + CNT_W'(1);
   end

   // R2: one step per tick
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count != '1) |=> count == $past(count) + CNT_W'(1));
   // R2: hold without tick
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));
   // R3: wrap to zero
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '1) |=> count == '0);
endmodule

// File: rtl/snapcnt_latch.sv
module snapcnt_latch #(
   parameter int CNT_W     = 64,
   parameter int LATCH_DLY = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CNT_W-1:0] count,
   output logic             busy,
   output logic [CNT_W-1:0] snap
);
   localparam int WAIT_W = (LATCH_DLY > 1) ? $clog2(LATCH_DLY) : 1;

   if (LATCH_DLY < 1) begin : g_bad_dly
      $error("snapcnt_latch: LATCH_DLY must be at least 1");
   end

   logic fin;

   if (LATCH_DLY == 1) begin : g_single
      assign fin = busy;
   end else begin : g_multi
      logic [WAIT_W-1:0] wait_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        wait_q <= '0;
         else if (req && !busy)             wait_q <= WAIT_W'(LATCH_DLY - 1);
         else if (busy && wait_q != '0)     wait_q <= wait_q - WAIT_W'(1);
      end

      assign fin = busy && (wait_q == '0);

      // R8: a request during the wait keeps the countdown going
      p_absorb_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (busy && !fin && req) |=> wait_q == $past(wait_q) - WAIT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            busy <= 1'b0;
      else if (req && !busy) busy <= 1'b1;
      else if (fin)          busy <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   snap <= '0;
      else if (fin) snap <= count;
   end

   // R4: an idle request raises busy
   p_busy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> busy);
   // R4: busy drops once the wait ends
   p_busy_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !busy);
   // R7: snapshot moves only at the end of a wait
   p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fin |=> $stable(snap));
   // R5: captured value equals the count of the final busy cycle
   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> snap == $past(count));
endmodule

// File: rtl/snapcnt_regs.sv
module snapcnt_regs
   import snapcnt_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 64
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic [CNT_W-1:0]  snap,
   output logic              req,
   output logic [DATA_W-1:0] rdata
);
   localparam int N_HALF = CNT_W / DATA_W;

   if (CNT_W % DATA_W != 0) begin : g_bad_split
      $error("snapcnt_regs: CNT_W must be a multiple of DATA_W");
   end
   if (DATA_W <= REQ_BIT) begin : g_bad_data
      $error("snapcnt_regs: DATA_W too narrow for the request bit");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("snapcnt_regs: ADDR_W must cover the register offsets");
   end

   logic [DATA_W-1:0] half [N_HALF];
   logic [N_HALF-1:0] half_hit;

   for (genvar i = 0; i < N_HALF; i++) begin : g_half
      assign half[i]     = snap[i*DATA_W +: DATA_W];
      assign half_hit[i] = (addr == ADDR_W'(ADR_HALF0) + ADDR_W'(i * HALF_STEP));
   end

   reg_sel_e sel;

   always_comb begin
      if (addr == ADDR_W'(ADR_CTRL)) sel = SEL_CTRL;
      else if (|half_hit)            sel = SEL_HALF;
      else                           sel = SEL_NONE;
   end

   assign req = wr_en && (sel == SEL_CTRL) && wdata[REQ_BIT];

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CTRL: rdata[REQ_BIT] = busy;
         SEL_HALF: begin
            for (int i = 0; i < N_HALF; i++)
               if (half_hit[i]) rdata = half[i];
         end
         default: rdata = '0;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;
endmodule

// File: rtl/snapcnt_top.sv
module snapcnt_top #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int LATCH_DLY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int CNT_W = 2 * DATA_W;

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] snap;
   logic             busy;
   logic             req;

   snapcnt_counter #(.CNT_W(CNT_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .count (count)
   );

   snapcnt_latch #(.CNT_W(CNT_W), .LATCH_DLY(LATCH_DLY)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .count (count),
      .busy  (busy),
      .snap  (snap)
   );

   snapcnt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .busy  (busy),
      .snap  (snap),
      .req   (req),
      .rdata (rdata)
   );

   // R9: snapshot changes only after a wait that a request began
   p_no_stray_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req) |=> $stable(snap));
endmodule

// File: tb/snapcnt_top_tb_top.sv
`timescale 1ns/1ps
module snapcnt_top_tb_top;
   localparam int DLY = 4;
   localparam logic [7:0] A_CTRL = 8'hA0;
   localparam logic [7:0] A_LO   = 8'hA4;
   localparam logic [7:0] A_HI   = 8'hA8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  rdata_s;
   logic [63:0] m;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   snapcnt_top #(.DATA_W(32), .ADDR_W(8), .LATCH_DLY(DLY)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata));

   // narrow instance: 8-bit count, wraps quickly
   snapcnt_top #(.DATA_W(4), .ADDR_W(8), .LATCH_DLY(DLY)) dut_s (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
      .addr(addr), .wdata(wdata[3:0]), .rdata(rdata_s));

   always @(posedge clk) begin
      if (!rst_n)    m <= '0;
      else if (tick) m <= m + 64'd1;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd64(output logic [63:0] v, output logic [7:0] vs);
      addr = A_HI; #1;
      v[63:32] = rdata; vs[7:4] = rdata_s;
      addr = A_LO; #1;
      v[31:0] = rdata; vs[3:0] = rdata_s;
   endtask

   task automatic latch(input bit extra, output int n, output logic [63:0] last);
      bit run = 1;
      n = 0;
      wr(A_CTRL, 32'h2);
      while (run) begin
         addr = A_CTRL; #1;
         if (rdata[1] !== 1'b1) run = 0;
         else begin
            if (n == 0) check("R10 ctrl read while busy", rdata, 64'h2);
            n++;
            last = m;
            if (extra && n == 1) begin wr_en = 1'b1; wdata = 32'h2; end
            @(negedge clk);
            wr_en = 1'b0;
            if (n > 50) run = 0;
         end
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      logic [63:0] v; logic [7:0] vs;
      do_reset();
      addr = A_CTRL; #1;
      check("R1 busy after reset", rdata, 64'h0);
      rd64(v, vs);
      check("R1 snapshot after reset", v, 64'h0);
      check("R1 narrow snapshot after reset", {56'h0, vs}, 64'h0);
   endtask

   task automatic t_count();
      int n; logic [63:0] last, v; logic [7:0] vs;
      tick = 1'b1;
      repeat (37) @(negedge clk);
      latch(0, n, last);
      check("R4 busy cycles", n, DLY);
      rd64(v, vs);
      check("R5 snapshot value", v, last);
      check("R6 halves coherent (narrow)", {56'h0, vs}, {56'h0, last[7:0]});
      for (int i = 0; i < 25; i++) begin
         @(negedge clk); tick = (i % 3) != 0;
      end
      latch(0, n, last);
      rd64(v, vs);
      check("R2 gated tick pattern", v, last);
      tick = 1'b0;
      latch(0, n, last);
      rd64(v, vs);
      check("R2 hold without tick", v, m);
      repeat (5) @(negedge clk);
      latch(0, n, last);
      begin
         logic [63:0] v2;
         rd64(v2, vs);
         check("R2 still held", v2, v);
      end
      tick = 1'b1;
   endtask

   task automatic t_absorb();
      int n; logic [63:0] last, v; logic [7:0] vs;
      latch(1, n, last);
      check("R8 absorbed second request", n, DLY);
      rd64(v, vs);
      check("R8 capture time unchanged", v, last);
   endtask

   task automatic t_hold();
      int n; logic [63:0] last, v, v2; logic [7:0] vs;
      latch(0, n, last);
      rd64(v, vs);
      repeat (12) @(negedge clk);
      rd64(v2, vs);
      check("R7 snapshot holds", v2, v);
      check("R7 counter moved on", (m > v) ? 64'd1 : 64'd0, 64'd1);
   endtask

   task automatic t_ignored();
      logic [63:0] v, v2; logic [7:0] vs;
      rd64(v, vs);
      wr(A_CTRL, 32'hFFFF_FFFD);
      addr = A_CTRL; #1;
      check("R9 bit1 clear no busy", rdata, 64'h0);
      wr(A_LO, 32'hFFFF_FFFF);
      wr(A_HI, 32'hFFFF_FFFF);
      addr = A_CTRL; #1;
      check("R9 half writes no busy", rdata, 64'h0);
      repeat (DLY + 2) @(negedge clk);
      rd64(v2, vs);
      check("R9 snapshot unchanged", v2, v);
   endtask

   task automatic t_decode();
      addr = 8'hAC; #1;
      check("R10 unmapped 0xAC", rdata, 64'h0);
      addr = 8'h00; #1;
      check("R10 unmapped 0x00", rdata, 64'h0);
      addr = A_CTRL; #1;
      check("R10 ctrl idle", rdata, 64'h0);
      addr = 8'hA4; #1;
      check("R6 low half at 0xA4 nonzero", (rdata != 0) ? 64'd1 : 64'd0, 64'd1);
   endtask

   task automatic t_wrap();
      int n; logic [63:0] last, v; logic [7:0] vs;
      do_reset();
      @(negedge clk); tick = 1'b1;
      repeat (300) @(negedge clk);
      latch(0, n, last);
      check("R3 passed all ones", (last > 64'd255) ? 64'd1 : 64'd0, 64'd1);
      rd64(v, vs);
      check("R3 narrow count wrapped", {56'h0, vs}, {56'h0, last[7:0]});
      check("R6 wide halves after wrap test", v, last);
   endtask

   initial begin
      t_reset();
      t_count();
      t_absorb();
      t_hold();
      t_ignored();
      t_decode();
      t_wrap();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule